// File: doc/BRIEF.md
# Two-Level Lookahead Adder-Subtractor

This block adds or subtracts two unsigned or two's-complement operands in a single combinational pass. Every bit position derives three local signals from its operand pair: a generate term (both bits set), a propagate term (either bit set) and a half-sum (the bits differ). The bits are split into fixed-width groups. Inside a group, every carry is a flat sum of products of the local terms and the group's incoming carry. A second lookahead stage works on the per-group generate and propagate terms and produces every group's incoming carry directly, so no carry ripples from one group to the next.

Subtraction uses the same datapath: the mode input complements the second operand before the bit cells, and the carry input then supplies the "+1" of the two's complement. With the carry input low in subtract mode the block computes a subtract-with-borrow (x − y − 1). The carry output follows the same convention, so in subtract mode it reads 1 when no borrow occurred. A signed overflow flag is taken from the carry entering the most significant bit and the carry leaving it. The block has no clock and holds no state; it is meant to sit between registers of the surrounding datapath.

Top module: `lka_addsub`

## Requirements
- R1: With `sub_i` = 0, `{cout_o, sum_o}` equals `x_i + y_i + cin_i` computed on WIDTH+1 bits.
- R2: With `sub_i` = 1 and `cin_i` = 1, `sum_o` equals `x_i − y_i` modulo 2^WIDTH, and `cout_o` is 1 exactly when `x_i` ≥ `y_i` as unsigned values.
- R3: With `sub_i` = 1 and `cin_i` = 0, `sum_o` equals `x_i − y_i − 1` modulo 2^WIDTH, and `cout_o` is 1 exactly when `x_i` > `y_i` as unsigned values.
- R4: With `sub_i` = 0, `ovf_o` is 1 exactly when the signed sum of `x_i`, `y_i` and `cin_i` lies outside the two's-complement range of WIDTH bits.
- R5: With `sub_i` = 1, `ovf_o` is 1 exactly when the signed value `x_i − y_i − (1 − cin_i)` lies outside the two's-complement range of WIDTH bits.
- R6: A carry entering at bit 0 reaches the carry output through every group when all bits propagate: `x_i` = 0xFFFF, `y_i` = 0x0000, `cin_i` = 1, `sub_i` = 0 gives `sum_o` = 0x0000 and `cout_o` = 1; in subtract mode equal operands with `cin_i` = 1 give `sum_o` = 0x0000 and `cout_o` = 1.
- R7: The outputs depend only on the present inputs: a new operand set is reflected on `sum_o`, `cout_o` and `ovf_o` without any clock edge.
- R8: The carry leaving each group, as formed inside the group, equals the incoming carry the second-level lookahead delivers to the next group (and the carry output for the last group).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x_i | input | WIDTH | First operand |
| y_i | input | WIDTH | Second operand; complemented internally in subtract mode |
| sub_i | input | 1 | Mode: 0 add, 1 subtract |
| cin_i | input | 1 | Carry input; in subtract mode 1 = no borrow pending, 0 = borrow pending |
| sum_o | output | WIDTH | Sum or difference |
| cout_o | output | 1 | Carry out; in subtract mode 1 = no borrow |
| ovf_o | output | 1 | Signed overflow |

## Verification
The bench builds the block with its defaults, WIDTH = 16 and GROUP = 4, which gives four groups and exercises both lookahead levels with a nontrivial second stage. With 16-bit operands the signed extremes 0x7FFF and 0x8000, all-zero and all-one words can be combined exhaustively in both modes and with both carry inputs, so every overflow direction and the full-length propagate path are reached directly. Several thousand seeded random operand pairs then cover mixed generate and propagate patterns across group boundaries.

// File: rtl/lka_pkg.sv
package lka_pkg;

  localparam int DEF_WIDTH = 16;
  localparam int DEF_GROUP = 4;

  typedef enum logic {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } lka_op_e;

  typedef struct packed {
    logic gen;
    logic prp;
  } lka_gp_t;

endpackage

// File: rtl/lka_bitcell.sv
module lka_bitcell #(
  parameter int W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] gen_o,
  output logic [W-1:0] prp_o,
  output logic [W-1:0] hsum_o
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign gen_o[i]  = a_i[i] & b_i[i];
    assign prp_o[i]  = a_i[i] | b_i[i];
    assign hsum_o[i] = a_i[i] ^ b_i[i];
  end

endmodule

// File: rtl/lka_carry_tree.sv
module lka_carry_tree #(
  parameter int N = 4
) (
  input  logic [N-1:0] gen_i,
  input  logic [N-1:0] prp_i,
  input  logic         cin_i,
  output logic [N:0]   carry_o,
  output logic         blk_gen_o,
  output logic         blk_prp_o
);

  // Every carry is an OR of AND terms, each starting at one generate
  // (or the incoming carry) and running through the propagates above it.
  always_comb begin
    logic term;
    logic acc;
    carry_o[0] = cin_i;
    for (int i = 1; i <= N; i++) begin
      term = cin_i;
      for (int k = 0; k < i; k++) term = term & prp_i[k];
      acc = term;
      for (int j = 0; j < i; j++) begin
        term = gen_i[j];
        for (int k = j + 1; k < i; k++) term = term & prp_i[k];
        acc = acc | term;
      end
      carry_o[i] = acc;
    end
  end

  // Block terms independent of the incoming carry, for the next level.
  always_comb begin
    logic term;
    logic acc;
    acc = 1'b0;
    for (int j = 0; j < N; j++) begin
      term = gen_i[j];
      for (int k = j + 1; k < N; k++) term = term & prp_i[k];
      acc = acc | term;
    end
    blk_gen_o = acc;
    blk_prp_o = &prp_i;
  end

endmodule

// File: rtl/lka_group.sv
module lka_group
  import lka_pkg::*;
#(
  parameter int GW = 4
) (
  input  logic [GW-1:0] gen_i,
  input  logic [GW-1:0] prp_i,
  input  logic [GW-1:0] hsum_i,
  input  logic          cin_i,
  output logic [GW-1:0] sum_o,
  output logic [GW:0]   carry_o,
  output lka_gp_t       gp_o
);

  logic blk_gen;
  logic blk_prp;

  lka_carry_tree #(.N(GW)) u_tree (
    .gen_i     (gen_i),
    .prp_i     (prp_i),
    .cin_i     (cin_i),
    .carry_o   (carry_o),
    .blk_gen_o (blk_gen),
    .blk_prp_o (blk_prp)
  );

  assign gp_o.gen = blk_gen;
  assign gp_o.prp = blk_prp;
  assign sum_o    = hsum_i ^ carry_o[GW-1:0];

  // R8: the group's own carry out agrees with its block terms.
  always_comb begin
    if (!$isunknown({gen_i, prp_i, cin_i})) begin
      p_grp_cout_r8: assert (carry_o[GW] == (blk_gen | (blk_prp & cin_i)))
        else $error("group carry out disagrees with block terms");
    end
  end

endmodule

// File: rtl/lka_addsub.sv
module lka_addsub
  import lka_pkg::*;
#(
  parameter int WIDTH = lka_pkg::DEF_WIDTH,
  parameter int GROUP = lka_pkg::DEF_GROUP
) (
  input  logic [WIDTH-1:0] x_i,
  input  logic [WIDTH-1:0] y_i,
  input  logic             sub_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o,
  output logic             ovf_o
);

  localparam int NGRP = WIDTH / GROUP;
  localparam int MSB  = WIDTH - 1;

  lka_op_e          op;
  logic [WIDTH-1:0] y_eff;
  logic [WIDTH-1:0] gen;
  logic [WIDTH-1:0] prp;
  logic [WIDTH-1:0] hsum;
  logic [WIDTH-1:0] bit_carry;
  logic [NGRP-1:0]  grp_gen;
  logic [NGRP-1:0]  grp_prp;
  logic [NGRP:0]    grp_cin;
  logic [GROUP:0]   grp_carry [NGRP];
  lka_gp_t          grp_gp    [NGRP];
  logic             top_gen_unused;
  logic             top_prp_unused;

  assign op    = lka_op_e'(sub_i);
  assign y_eff = (op == OP_SUB) ? ~y_i : y_i;

  lka_bitcell #(.W(WIDTH)) u_bits (
    .a_i    (x_i),
    .b_i    (y_eff),
    .gen_o  (gen),
    .prp_o  (prp),
    .hsum_o (hsum)
  );

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    lka_group #(.GW(GROUP)) u_group (
      .gen_i   (gen[g*GROUP +: GROUP]),
      .prp_i   (prp[g*GROUP +: GROUP]),
      .hsum_i  (hsum[g*GROUP +: GROUP]),
      .cin_i   (grp_cin[g]),
      .sum_o   (sum_o[g*GROUP +: GROUP]),
      .carry_o (grp_carry[g]),
      .gp_o    (grp_gp[g])
    );
    assign grp_gen[g]                  = grp_gp[g].gen;
    assign grp_prp[g]                  = grp_gp[g].prp;
    assign bit_carry[g*GROUP +: GROUP] = grp_carry[g][GROUP-1:0];

    // R8: intra-group carry out matches the second-level carry.
    always_comb begin
      if (!$isunknown({x_i, y_i, sub_i, cin_i})) begin
        p_grp_link_r8: assert (grp_carry[g][GROUP] == grp_cin[g+1])
          else $error("group %0d carry out differs from next group carry in", g);
      end
    end
  end

  // Second lookahead level across groups.
  lka_carry_tree #(.N(NGRP)) u_grp_tree (
    .gen_i     (grp_gen),
    .prp_i     (grp_prp),
    .cin_i     (cin_i),
    .carry_o   (grp_cin),
    .blk_gen_o (top_gen_unused),
    .blk_prp_o (top_prp_unused)
  );

  assign cout_o = grp_cin[NGRP];
  assign ovf_o  = bit_carry[MSB] ^ grp_cin[NGRP];

  // Arithmetic cross-checks at the block boundary.
  logic [WIDTH:0] ref_add;
  logic [WIDTH:0] ref_sub;
  assign ref_add = {1'b0, x_i} + {1'b0, y_i} + {{WIDTH{1'b0}}, cin_i};
  assign ref_sub = {1'b0, x_i} + {1'b0, ~y_i} + {{WIDTH{1'b0}}, cin_i};

  always_comb begin
    if (!$isunknown({x_i, y_i, sub_i, cin_i})) begin
      if (op == OP_ADD) begin
        p_add_result_r1: assert ({cout_o, sum_o} == ref_add)
          else $error("add result mismatch");
        p_add_ovf_r4: assert (ovf_o == ((x_i[MSB] == y_i[MSB]) && (sum_o[MSB] != x_i[MSB])))
          else $error("add overflow mismatch");
      end else begin
        if (cin_i) begin
          p_sub_result_r2: assert ((sum_o == x_i - y_i) && (cout_o == (x_i >= y_i)))
            else $error("subtract result mismatch");
        end else begin
          p_sbb_result_r3: assert ((sum_o == x_i - y_i - 1'b1) && (cout_o == (x_i > y_i)))
            else $error("subtract-with-borrow result mismatch");
        end
        p_sub_ovf_r5: assert (ovf_o == ((x_i[MSB] != y_i[MSB]) && (sum_o[MSB] != x_i[MSB])))
          else $error("subtract overflow mismatch");
      end
      p_no_top_carry_r6: assert (cout_o == ref_sub[WIDTH] || op == OP_ADD)
        else $error("subtract carry chain mismatch");
    end
  end

  always_comb begin
    if (!$isunknown({top_gen_unused, top_prp_unused, cin_i})) begin
      p_top_block_r8: assert (cout_o == (top_gen_unused | (top_prp_unused & cin_i)))
        else $error("top block terms disagree with carry out");
    end
  end

endmodule

// File: tb/lka_addsub_tb_top.sv
`timescale 1ns/1ps
module lka_addsub_tb_top;

  localparam int W = 16;

  logic         clk;
  logic [W-1:0] x, y;
  logic         sub, cin;
  logic [W-1:0] sum;
  logic         cout, ovf;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  initial clk = 1'b0;
  always #2 clk = ~clk;

  lka_addsub #(.WIDTH(W), .GROUP(4)) dut_i (
    .x_i    (x),
    .y_i    (y),
    .sub_i  (sub),
    .cin_i  (cin),
    .sum_o  (sum),
    .cout_o (cout),
    .ovf_o  (ovf)
  );

  // Expected {ovf, cout, sum} from integer arithmetic.
  function automatic logic [W+1:0] model(input logic [W-1:0] a, input logic [W-1:0] b,
                                         input logic s, input logic c);
    int ua, ub, sa, sb, ures, sres;
    logic co, ov;
    ua = int'(a);
    ub = int'(b);
    sa = int'($signed(a));
    sb = int'($signed(b));
    if (!s) begin
      ures = ua + ub + int'(c);
      sres = sa + sb + int'(c);
      co   = (ures >= 65536);
    end else begin
      ures = ua - ub - (1 - int'(c));
      sres = sa - sb - (1 - int'(c));
      co   = (ures >= 0);
    end
    ov = (sres > 32767) || (sres < -32768);
    return {ov, co, W'(ures)};
  endfunction

  function automatic string tag_of(input logic s, input logic c);
    if (!s) return "R1/R4";
    if (c)  return "R2/R5";
    return "R3/R5";
  endfunction

  task automatic check(input string tag, input logic [W+1:0] exp);
    n_checks++;
    if ({ovf, cout, sum} !== exp) begin
      n_fail++;
      $display("FAIL %s: x=%h y=%h sub=%b cin=%b got sum=%h cout=%b ovf=%b expected sum=%h cout=%b ovf=%b",
               tag, x, y, sub, cin, sum, cout, ovf, exp[W-1:0], exp[W], exp[W+1]);
    end
  endtask

  // Drive after a falling edge, sample 1 ns later with no clock edge between (R7).
  task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic s, input logic c, input string tag);
    @(negedge clk);
    x = a; y = b; sub = s; cin = c;
    #1;
    check(tag, model(a, b, s, c));
  endtask

  logic [W-1:0] corners [6];

  initial begin
    x = '0; y = '0; sub = 1'b0; cin = 1'b0;
    corners[0] = 16'h0000; corners[1] = 16'hFFFF; corners[2] = 16'h8000;
    corners[3] = 16'h7FFF; corners[4] = 16'h0001; corners[5] = 16'h00F0;
    void'($urandom(32'd20240611));

    // Idle state: zero operands give zero result, no carry, no overflow (R1).
    apply(16'h0000, 16'h0000, 1'b0, 1'b0, "R1 idle");

    // R6: full-length propagate chains.
    apply(16'hFFFF, 16'h0000, 1'b0, 1'b1, "R6 add propagate");
    apply(16'h1234, 16'h1234, 1'b1, 1'b1, "R6 sub equal");
    apply(16'h0FFF, 16'h0001, 1'b0, 1'b0, "R6 group boundary");

    // R4/R5 overflow extremes.
    apply(16'h7FFF, 16'h0001, 1'b0, 1'b0, "R4 positive overflow");
    apply(16'h8000, 16'hFFFF, 1'b0, 1'b0, "R4 negative overflow");
    apply(16'h8000, 16'h0001, 1'b1, 1'b1, "R5 sub overflow");
    apply(16'h7FFF, 16'hFFFF, 1'b1, 1'b1, "R5 sub overflow positive");
    apply(16'h0000, 16'h0000, 1'b1, 1'b0, "R3 borrow from zero");
    apply(16'h0005, 16'h0003, 1'b1, 1'b1, "R2 small difference");

    // Directed corner cross product in every mode.
    for (int i = 0; i < 6; i++)
      for (int j = 0; j < 6; j++)
        for (int m = 0; m < 4; m++)
          apply(corners[i], corners[j], m[1], m[0], tag_of(m[1], m[0]));

    // Seeded random operands.
    for (int n = 0; n < 4000; n++) begin
      logic [W-1:0] a, b;
      logic s, c;
      a = W'($urandom);
      b = W'($urandom);
      s = 1'($urandom);
      c = 1'($urandom);
      apply(a, b, s, c, tag_of(s, c));
    end

    // R7: change inputs between edges and observe at once.
    @(posedge clk);
    #1;
    x = 16'h00FF; y = 16'h0001; sub = 1'b0; cin = 1'b0;
    #0.5;
    check("R7 no clock needed", model(16'h00FF, 16'h0001, 1'b0, 1'b0));

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

endmodule